// File: doc/BRIEF.md
# Compensated Time-of-Day Counter

This block keeps a time-of-day value made of a nanosecond count, a 32-bit fraction of a nanosecond and a 32-bit seconds count. While counting is enabled, it adds a programmable 64-bit fixed-point step to the combined nanosecond and fraction value on every core clock cycle. The upper half of the step is whole nanoseconds and the lower half is the fraction. When the nanosecond part reaches a programmable rollover value, normally 1,000,000,000, the excess stays in the nanosecond count and the seconds count advances by one.

Software writes a small register set through a single-cycle write port. The registers hold the step, the rollover value, staged time values and a control word. The control word carries an enable and an operation code. A set, an increment or a decrement then corrects the clock in a single step. The block also tracks a pair of absolute rollover points: the instant of the second boundary that was last crossed and the instant of the next one. A set loads both points, and every crossing moves them.

Top module: `tod_clock`

## Requirements
- R1: While the enable is 1 and no operation is being applied, each clock cycle adds the 64-bit step (bits 63:32 whole nanoseconds, bits 31:0 fraction) to the concatenation {nanoseconds, fraction}.
- R2: When the nanosecond sum after a step reaches or passes the rollover value, the nanosecond output becomes the sum minus the rollover value and the seconds count rises by one. A sum of rollover-1 does not wrap.
- R3: The seconds count is 32 bits wide and wraps modulo 2^32 in both directions: 0xFFFFFFFF+1 gives 0 and 0-1 gives 0xFFFFFFFF.
- R4: Operation code 1 (set) loads the staged nanoseconds, fraction, seconds, current point and next point in a single cycle. No step is added in that cycle.
- R5: Operation code 3 (increment) adds the staged nanosecond delta, which is below the rollover value. It carries into the seconds count as in R2 and leaves the fraction unchanged. No step is added in that cycle.
- R6: Operation code 4 (decrement) subtracts the staged nanosecond delta and leaves the fraction unchanged. If the delta exceeds the nanosecond count, the rollover value is added back and the seconds count drops by one.
- R7: With the enable at 0 and no operation pending, nanoseconds, fraction, seconds and both points hold.
- R8: Operation codes 0, 2, 5, 6 and 7 apply no correction. The clock behaves as R1 or R7.
- R9: A write of the control word takes effect at the next clock edge. The operation code then clears itself, so each write applies its operation exactly once.
- R10: At each forward carry, the current point takes the old next point and the next point grows by the rollover value. At each decrement borrow, the next point takes the old current point and the current point drops by the rollover value.
- R11: After reset: nanoseconds, fraction, seconds, current point and step are 0, the enable is 0, the rollover value is 1,000,000,000 and the next point is 1,000,000,000.
- R12: Write addresses:
  - 0: control word. Bit 0 is the enable and bits 3:1 are the operation code.
  - 1: step (64 bits).
  - 2: rollover value (bits 31:0).
  - 3: staged nanoseconds or delta (bits 31:0).
  - 4: staged fraction (bits 31:0).
  - 5: staged seconds (bits 31:0).
  - 6: staged current point (64 bits).
  - 7: staged next point (64 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 64 | Register write data |
| ns_o | output | 32 | Nanosecond count |
| frac_o | output | 32 | Fraction of a nanosecond |
| sec_o | output | 32 | Seconds count |
| cur_pt_o | output | 64 | Absolute time of the last second boundary |
| nxt_pt_o | output | 64 | Absolute time of the next second boundary |

## Verification
The assertions assume the following about software:
- The step's whole-nanosecond part and every staged nanosecond value or delta stay below the rollover value.
- The rollover value is rewritten only while the nanosecond count is already below the new value.

Only under these conditions can one subtraction keep the count in range. The stimulus always sets the time to zero before it shrinks the rollover value. It draws random steps and deltas below the rollover value in force at the time.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam logic [2:0] OP_NONE = 3'd0;
  localparam logic [2:0] OP_SET  = 3'd1;
  localparam logic [2:0] OP_INC  = 3'd3;
  localparam logic [2:0] OP_DEC  = 3'd4;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_STEP  = 3'd1;
  localparam logic [2:0] A_ROLL  = 3'd2;
  localparam logic [2:0] A_SNS   = 3'd3;
  localparam logic [2:0] A_SFRAC = 3'd4;
  localparam logic [2:0] A_SSEC  = 3'd5;
  localparam logic [2:0] A_SCUR  = 3'd6;
  localparam logic [2:0] A_SNXT  = 3'd7;
endpackage

// File: rtl/tod_cfg_regs.sv
module tod_cfg_regs
  import tod_pkg::*;
#(
  parameter int NS_W     = 32,
  parameter int FRAC_W   = 32,
  parameter int SEC_W    = 32,
  parameter int PT_W     = 64,
  parameter int DATA_W   = 64,
  parameter logic [NS_W-1:0] ROLL_DEF = 32'd1_000_000_000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [2:0]             wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  output logic                   en_q,
  output logic [2:0]             op_q,
  output logic [NS_W+FRAC_W-1:0] step_q,
  output logic [NS_W-1:0]        roll_q,
  output logic [NS_W-1:0]        stg_ns_q,
  output logic [FRAC_W-1:0]      stg_frac_q,
  output logic [SEC_W-1:0]       stg_sec_q,
  output logic [PT_W-1:0]        stg_cur_q,
  output logic [PT_W-1:0]        stg_nxt_q
);
  localparam int ACC_W = NS_W + FRAC_W;

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

  // strobe: lives for exactly one cycle after a control write
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q <= OP_NONE;
      en_q <= 1'b0;
    end else begin
      op_q <= ctrl_wr ? wr_data[3:1] : OP_NONE;
      if (ctrl_wr) en_q <= wr_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q     <= '0;
      roll_q     <= ROLL_DEF;
      stg_ns_q   <= '0;
      stg_frac_q <= '0;
      stg_sec_q  <= '0;
      stg_cur_q  <= '0;
      stg_nxt_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_STEP:  step_q     <= wr_data[ACC_W-1:0];
        A_ROLL:  roll_q     <= wr_data[NS_W-1:0];
        A_SNS:   stg_ns_q   <= wr_data[NS_W-1:0];
        A_SFRAC: stg_frac_q <= wr_data[FRAC_W-1:0];
        A_SSEC:  stg_sec_q  <= wr_data[SEC_W-1:0];
        A_SCUR:  stg_cur_q  <= wr_data[PT_W-1:0];
        A_SNXT:  stg_nxt_q  <= wr_data[PT_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tod_ns_accum.sv
module tod_ns_accum
  import tod_pkg::*;
#(
  parameter int NS_W   = 32,
  parameter int FRAC_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic [2:0]             op,
  input  logic [NS_W+FRAC_W-1:0] step,
  input  logic [NS_W-1:0]        roll,
  input  logic [NS_W-1:0]        stg_ns,
  input  logic [FRAC_W-1:0]      stg_frac,
  output logic [NS_W-1:0]        ns_q,
  output logic [FRAC_W-1:0]      frac_q,
  output logic                   carry,
  output logic                   borrow
);
  localparam int ACC_W = NS_W + FRAC_W;

  logic [ACC_W:0]      sum;
  logic [NS_W:0]       sum_ns;
  logic [NS_W:0]       add_ns;
  logic [NS_W:0]       roll_x;
  logic [NS_W:0]       wrap_sum;
  logic [NS_W:0]       wrap_add;
  logic [NS_W-1:0]     nxt_ns;
  logic [FRAC_W-1:0]   nxt_frac;

  assign roll_x   = {1'b0, roll};
  assign sum      = {1'b0, ns_q, frac_q} + {1'b0, step};
  assign sum_ns   = sum[ACC_W:FRAC_W];
  assign add_ns   = {1'b0, ns_q} + {1'b0, stg_ns};
  assign wrap_sum = sum_ns - roll_x;
  assign wrap_add = add_ns - roll_x;

  always_comb begin
    nxt_ns   = ns_q;
    nxt_frac = frac_q;
    carry    = 1'b0;
    borrow   = 1'b0;
    case (op)
      OP_SET: begin
        nxt_ns   = stg_ns;
        nxt_frac = stg_frac;
      end
      OP_INC: begin
        if (add_ns >= roll_x) begin
          nxt_ns = wrap_add[NS_W-1:0];
          carry  = 1'b1;
        end else begin
          nxt_ns = add_ns[NS_W-1:0];
        end
      end
      OP_DEC: begin
        if (ns_q >= stg_ns) begin
          nxt_ns = ns_q - stg_ns;
        end else begin
          nxt_ns = ns_q + roll - stg_ns;
          borrow = 1'b1;
        end
      end
      default: begin
        if (en) begin
          nxt_frac = sum[FRAC_W-1:0];
          if (sum_ns >= roll_x) begin
            nxt_ns = wrap_sum[NS_W-1:0];
            carry  = 1'b1;
          end else begin
            nxt_ns = sum_ns[NS_W-1:0];
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ns_q   <= '0;
      frac_q <= '0;
    end else begin
      ns_q   <= nxt_ns;
      frac_q <= nxt_frac;
    end
  end

  // R2
  ns_range_chk: assert property (@(posedge clk) disable iff (rst)
    ns_q < roll);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && op == OP_NONE) |=> ($stable(ns_q) && $stable(frac_q)));

  // R5
  frac_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_INC || op == OP_DEC) |=> $stable(frac_q));
endmodule

// File: rtl/tod_sec_track.sv
module tod_sec_track #(
  parameter int NS_W  = 32,
  parameter int SEC_W = 32,
  parameter int PT_W  = 64,
  parameter logic [NS_W-1:0] ROLL_DEF = 32'd1_000_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set,
  input  logic             carry,
  input  logic             borrow,
  input  logic [NS_W-1:0]  roll,
  input  logic [SEC_W-1:0] stg_sec,
  input  logic [PT_W-1:0]  stg_cur,
  input  logic [PT_W-1:0]  stg_nxt,
  output logic [SEC_W-1:0] sec_q,
  output logic [PT_W-1:0]  cur_q,
  output logic [PT_W-1:0]  nxt_q
);
  localparam logic [SEC_W-1:0] ONE_S = SEC_W'(1);

  logic [PT_W-1:0] roll_x;
  assign roll_x = {{(PT_W-NS_W){1'b0}}, roll};

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      cur_q <= '0;
      nxt_q <= {{(PT_W-NS_W){1'b0}}, ROLL_DEF};
    end else if (set) begin
      sec_q <= stg_sec;
      cur_q <= stg_cur;
      nxt_q <= stg_nxt;
    end else if (carry) begin
      sec_q <= sec_q + ONE_S;
      cur_q <= nxt_q;
      nxt_q <= nxt_q + roll_x;
    end else if (borrow) begin
      sec_q <= sec_q - ONE_S;
      nxt_q <= cur_q;
      cur_q <= cur_q - roll_x;
    end
  end

  // R2
  sec_step_chk: assert property (@(posedge clk) disable iff (rst)
    carry |=> sec_q == $past(sec_q) + ONE_S);

  // R6
  sec_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    borrow |=> sec_q == $past(sec_q) - ONE_S);

  // R10
  pts_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    carry |=> (cur_q == $past(nxt_q)) && (nxt_q == $past(nxt_q) + $past(roll_x)));

  // R10
  pts_back_chk: assert property (@(posedge clk) disable iff (rst)
    borrow |=> (nxt_q == $past(cur_q)) && (cur_q == $past(cur_q) - $past(roll_x)));
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int NS_W   = 32,
  parameter int FRAC_W = 32,
  parameter int SEC_W  = 32,
  parameter int PT_W   = 64,
  parameter int DATA_W = 64,
  parameter logic [NS_W-1:0] ROLL_DEF = 32'd1_000_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NS_W-1:0]   ns_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [SEC_W-1:0]  sec_o,
  output logic [PT_W-1:0]   cur_pt_o,
  output logic [PT_W-1:0]   nxt_pt_o
);
  localparam int ACC_W = NS_W + FRAC_W;

  logic              en_q;
  logic [2:0]        op_q;
  logic [ACC_W-1:0]  step_q;
  logic [NS_W-1:0]   roll_q;
  logic [NS_W-1:0]   stg_ns;
  logic [FRAC_W-1:0] stg_frac;
  logic [SEC_W-1:0]  stg_sec;
  logic [PT_W-1:0]   stg_cur;
  logic [PT_W-1:0]   stg_nxt;
  logic              carry;
  logic              borrow;

  tod_cfg_regs #(
    .NS_W(NS_W), .FRAC_W(FRAC_W), .SEC_W(SEC_W), .PT_W(PT_W),
    .DATA_W(DATA_W), .ROLL_DEF(ROLL_DEF)
  ) cfg_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en_q(en_q), .op_q(op_q), .step_q(step_q), .roll_q(roll_q),
    .stg_ns_q(stg_ns), .stg_frac_q(stg_frac), .stg_sec_q(stg_sec),
    .stg_cur_q(stg_cur), .stg_nxt_q(stg_nxt)
  );

  tod_ns_accum #(.NS_W(NS_W), .FRAC_W(FRAC_W)) acc_i (
    .clk(clk), .rst(rst), .en(en_q), .op(op_q), .step(step_q), .roll(roll_q),
    .stg_ns(stg_ns), .stg_frac(stg_frac), .ns_q(ns_o), .frac_q(frac_o),
    .carry(carry), .borrow(borrow)
  );

  tod_sec_track #(
    .NS_W(NS_W), .SEC_W(SEC_W), .PT_W(PT_W), .ROLL_DEF(ROLL_DEF)
  ) sec_i (
    .clk(clk), .rst(rst), .set(op_q == OP_SET), .carry(carry), .borrow(borrow),
    .roll(roll_q), .stg_sec(stg_sec), .stg_cur(stg_cur), .stg_nxt(stg_nxt),
    .sec_q(sec_o), .cur_q(cur_pt_o), .nxt_q(nxt_pt_o)
  );
endmodule

// File: tb/tod_clock_tb_top.sv
module tod_clock_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [63:0] wr_data;
  logic [31:0] ns_o, frac_o, sec_o;
  logic [63:0] cur_pt_o, nxt_pt_o;

  always #2 clk = ~clk;

  tod_clock dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ns_o(ns_o), .frac_o(frac_o), .sec_o(sec_o),
    .cur_pt_o(cur_pt_o), .nxt_pt_o(nxt_pt_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit started = 0;

  // behavioural reference state
  logic [31:0] m_ns, m_frac, m_sec, m_roll, m_sns, m_sfrac, m_ssec;
  logic [63:0] m_step, m_cur, m_nxt, m_scur, m_snxt;
  logic        m_en;
  logic [2:0]  m_op;
  logic [64:0] m_sum;
  logic [32:0] m_t;
  logic        m_carry, m_borrow;
  string       m_tag, s_tag;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_ns = 0; m_frac = 0; m_sec = 0; m_roll = 32'd1_000_000_000;
      m_step = 0; m_cur = 0; m_nxt = 64'd1_000_000_000; m_en = 0; m_op = 0;
      m_sns = 0; m_sfrac = 0; m_ssec = 0; m_scur = 0; m_snxt = 0;
      m_tag = "R11";
    end else begin
      m_carry = 0; m_borrow = 0; m_tag = "R1";
      if (m_op == 3'd1) begin
        m_ns = m_sns; m_frac = m_sfrac; m_sec = m_ssec;
        m_cur = m_scur; m_nxt = m_snxt; m_tag = "R4";
      end else if (m_op == 3'd3) begin
        m_t = {1'b0, m_ns} + {1'b0, m_sns};
        if (m_t >= {1'b0, m_roll}) begin m_t = m_t - {1'b0, m_roll}; m_carry = 1; end
        m_ns = m_t[31:0]; m_tag = "R5";
      end else if (m_op == 3'd4) begin
        if (m_ns >= m_sns) m_ns = m_ns - m_sns;
        else begin m_ns = m_ns + m_roll - m_sns; m_borrow = 1; end
        m_tag = "R6";
      end else begin
        if (m_op != 0) m_tag = "R8";
        if (m_en) begin
          m_sum = {1'b0, m_ns, m_frac} + {1'b0, m_step};
          m_frac = m_sum[31:0];
          m_t = m_sum[64:32];
          if (m_t >= {1'b0, m_roll}) begin
            m_t = m_t - {1'b0, m_roll}; m_carry = 1; m_tag = "R2";
          end
          m_ns = m_t[31:0];
        end else if (m_op == 0) m_tag = "R7";
      end
      s_tag = m_tag;
      if (m_carry) begin
        if (m_sec == 32'hFFFF_FFFF) s_tag = "R3";
        m_sec = m_sec + 1; m_cur = m_nxt; m_nxt = m_nxt + {32'd0, m_roll};
      end
      if (m_borrow) begin
        if (m_sec == 0) s_tag = "R3";
        m_sec = m_sec - 1; m_nxt = m_cur; m_cur = m_cur - {32'd0, m_roll};
      end
      // R12 address map
      m_op = 0;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_en = wr_data[0]; m_op = wr_data[3:1]; end
          3'd1: m_step = wr_data;
          3'd2: m_roll = wr_data[31:0];
          3'd3: m_sns = wr_data[31:0];
          3'd4: m_sfrac = wr_data[31:0];
          3'd5: m_ssec = wr_data[31:0];
          3'd6: m_scur = wr_data;
          default: m_snxt = wr_data;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk(m_tag, "ns", {32'd0, ns_o}, {32'd0, m_ns});
      chk(m_tag, "frac", {32'd0, frac_o}, {32'd0, m_frac});
      chk(s_tag, "sec", {32'd0, sec_o}, {32'd0, m_sec});
      chk("R10", "cur_pt", cur_pt_o, m_cur);
      chk("R10", "nxt_pt", nxt_pt_o, m_nxt);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] h;
    rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0;
    repeat (4) @(negedge clk);
    // R11 reset values
    chk("R11", "ns", {32'd0, ns_o}, 64'd0);
    chk("R11", "sec", {32'd0, sec_o}, 64'd0);
    chk("R11", "nxt_pt", nxt_pt_o, 64'd1_000_000_000);
    rst = 0;
    // R1 plain counting
    wr(3'd1, {32'd4, 32'h4000_0000});
    wr(3'd0, 64'd1);
    idle(10);
    // R4 set near a boundary, then R2 wrap with excess kept
    wr(3'd3, 64'd999_999_980); wr(3'd4, 64'd0); wr(3'd5, 64'd7);
    wr(3'd6, 64'd7_000_000_000); wr(3'd7, 64'd8_000_000_000);
    wr(3'd0, 64'h3);
    idle(20);
    // R7 hold
    wr(3'd0, 64'd0);
    h = ns_o;
    idle(6);
    chk("R7", "ns held", {32'd0, ns_o}, {32'd0, h});
    // R9 single application
    h = ns_o;
    wr(3'd3, 64'd100);
    wr(3'd0, 64'd3 << 1);
    idle(5);
    chk("R9", "ns once", {32'd0, ns_o}, {32'd0, h + 32'd100});
    // R5 increment with carry
    wr(3'd3, 64'd999_999_999); wr(3'd0, 64'd3 << 1); idle(3);
    // R6 decrement with borrow
    wr(3'd3, 64'd999_999_990); wr(3'd0, 64'd4 << 1); idle(3);
    // R8 other codes
    for (int c = 2; c < 8; c++) begin
      if (c != 3 && c != 4) begin
        h = ns_o;
        wr(3'd0, 64'(c) << 1);
        idle(2);
        chk("R8", "ns unchanged", {32'd0, ns_o}, {32'd0, h});
      end
    end
    // R3 forward wrap of seconds
    wr(3'd3, 64'd999_999_996); wr(3'd5, 64'hFFFF_FFFF);
    wr(3'd0, 64'h3); idle(4);
    chk("R3", "sec wrapped", {32'd0, sec_o}, 64'd0);
    // R3 backward wrap through decrement borrow
    wr(3'd0, 64'd0);
    wr(3'd3, 64'd10); wr(3'd5, 64'd0); wr(3'd0, 64'd1 << 1); idle(2);
    wr(3'd3, 64'd20); wr(3'd0, 64'd4 << 1); idle(2);
    chk("R3", "sec underflow", {32'd0, sec_o}, 64'hFFFF_FFFF);
    chk("R6", "ns borrow", {32'd0, ns_o}, 64'd999_999_990);
    // small rollover, many wraps with fractional carries
    wr(3'd3, 64'd0); wr(3'd4, 64'd0); wr(3'd5, 64'd0);
    wr(3'd6, 64'd0); wr(3'd7, 64'd1000);
    wr(3'd0, 64'd1 << 1); idle(2);
    wr(3'd2, 64'd1000);
    wr(3'd1, {32'd37, 32'h8000_0000});
    wr(3'd0, 64'd1);
    idle(200);
    for (int i = 0; i < 30; i++) begin
      wr(3'd1, {32'($urandom_range(0, 299)), 32'($urandom)});
      idle(15);
      wr(3'd3, 64'($urandom_range(0, 999)));
      wr(3'd0, (i % 2 == 0) ? 64'h7 : 64'h9);
      idle(3);
    end
    wr(3'd0, 64'd0);
    idle(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule